// File: doc/BRIEF.md
# Modbus ASCII LRC Generator

This block computes the longitudinal redundancy check for one Modbus ASCII message as its bytes stream past. The upstream source marks the first byte of a message with a start flag and the last byte with an end flag. A leading colon on the start byte is left out of the sum. A carriage return followed by a line feed, when they are the last two bytes, is also left out. Every other byte adds its full 8-bit value into a running sum, and any carry is dropped. When the end byte is accepted, the block forms the two's complement of that sum. It presents the result as a single-entry output stream, along with a flag that says whether it matches a check byte supplied with the end beat.

Input bytes use a valid/ready handshake. A byte is consumed on any clock edge where `in_valid` and `in_ready` are both high. The result uses a valid/ready handshake as well. `res_valid` stays high, and `res_lrc`/`res_match` hold their values, until a cycle in which `res_ready` is high. While a result is waiting and `res_ready` is low, `in_ready` is low, so no input byte is lost and no result is overwritten. When `res_ready` is high, input flows without stalls.

Top module: `lrc_gen`

## Requirements
- R1: An accepted byte with `in_som` high starts a message. If that byte is a colon (0x3A), it is not summed; any other start byte is summed.
- R2: A carriage return (0x0D) followed by a line feed (0x0A) carrying `in_eom` is excluded from the sum. A lone CR or LF at the end, or the pair in any other order or position, is summed like any other byte.
- R3: The sum is kept in 8 bits, and any carry out of bit 7 is discarded.
- R4: `res_lrc` equals (0xFF minus the 8-bit sum) plus 1, modulo 256, which is the two's complement of the sum.
- R5: `res_valid` rises on the clock edge that accepts the `in_eom` byte of a message, and falls after the first edge on which `res_ready` is high.
- R6: `res_match` is high exactly when `res_lrc` equals the `in_chk` value presented with the accepted `in_eom` byte.
- R7: A byte accepted outside a message (no `in_som` since reset or since the last end byte) is ignored. It produces no result, even when it carries `in_eom`.
- R8: While `res_valid` is high and `res_ready` is low, `in_ready` is low and `res_lrc`/`res_match` stay unchanged.
- R9: After reset, `res_valid` is low and `in_ready` is high.
- R10: An `in_som` byte arriving inside an unfinished message discards the earlier partial sum and restarts the message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Message byte |
| in_som | input | 1 | Byte is the first of a message |
| in_eom | input | 1 | Byte is the last of a message |
| in_chk | input | 8 | Check byte to compare against, sampled with the end byte |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_lrc | output | 8 | Computed check byte |
| res_match | output | 1 | Computed check byte equals the supplied one |

## Verification
The bench builds the block with its defaults: 8-bit bytes and trailer stripping enabled. This small configuration makes exhaustive sweeps cheap. Every one of the 256 single-byte messages is sent, with the check byte alternating between right and wrong. A grid of two-byte bodies with a full colon/CR/LF frame is also sent, so each modular sum and its negation are checked arithmetically. Directed messages cover the odd trailers, the colon rule, a long run of 0xFF that wraps the sum many times, a restart in mid-message, stray bytes outside any message, and a stalled consumer.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CH_COLON = 8'h3A;
  localparam byte_t CH_CR    = 8'h0D;
  localparam byte_t CH_LF    = 8'h0A;

  function automatic byte_t twos_neg(input byte_t s);
    return byte_t'(~s) + byte_t'(1);
  endfunction
endpackage

// File: rtl/lrc_frame_track.sv
module lrc_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic som,
  input  logic eom,
  output logic take
);
  logic active_q;

  assign take = beat & (som | active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (take) begin
      active_q <= !eom;
    end
  end
endmodule

// File: rtl/lrc_accum.sv
module lrc_accum
  import lrc_pkg::*;
#(
  parameter bit STRIP_TRAILER = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  som,
  input  logic  eom,
  input  byte_t data,
  output logic  fin,
  output byte_t total
);
  byte_t sum_q;
  byte_t held_q;
  logic  held_v_q;

  byte_t base;
  logic  hv;
  logic  cur_ok;
  logic  pair;
  byte_t with_held;

  always_comb begin
    base      = som ? '0 : sum_q;
    hv        = !som && held_v_q;
    cur_ok    = !(som && (data == CH_COLON));
    with_held = base + (hv ? held_q : '0);
  end

  generate
    if (STRIP_TRAILER) begin : g_strip
      assign pair = hv && (held_q == CH_CR) && (data == CH_LF);
    end else begin : g_keep
      assign pair = 1'b0;
    end
  endgenerate

  assign total = pair ? base : (with_held + (cur_ok ? data : '0));
  assign fin   = take & eom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else if (take) begin
      if (eom) begin
        sum_q    <= '0;
        held_v_q <= 1'b0;
      end else begin
        sum_q    <= with_held;
        held_q   <= data;
        held_v_q <= cur_ok;
      end
    end
  end
endmodule

// File: rtl/lrc_result.sv
module lrc_result
  import lrc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fin,
  input  byte_t total,
  input  byte_t chk,
  input  logic  res_ready,
  output logic  res_valid,
  output byte_t res_lrc,
  output logic  res_match
);
  byte_t lrc_n;
  assign lrc_n = twos_neg(total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lrc   <= '0;
      res_match <= 1'b0;
    end else if (fin) begin
      res_valid <= 1'b1;
      res_lrc   <= lrc_n;
      res_match <= (lrc_n == chk);
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lrc_gen.sv
module lrc_gen
  import lrc_pkg::*;
#(
  parameter bit STRIP_TRAILER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_som,
  input  logic              in_eom,
  input  logic [BYTE_W-1:0] in_chk,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [BYTE_W-1:0] res_lrc,
  output logic              res_match
);
  logic  beat;
  logic  take;
  logic  fin;
  byte_t total;

  assign in_ready = !res_valid || res_ready;
  assign beat     = in_valid && in_ready;

  lrc_frame_track u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .som   (in_som),
    .eom   (in_eom),
    .take  (take)
  );

  lrc_accum #(.STRIP_TRAILER(STRIP_TRAILER)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .som   (in_som),
    .eom   (in_eom),
    .data  (in_data),
    .fin   (fin),
    .total (total)
  );

  lrc_result u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .total     (total),
    .chk       (in_chk),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_lrc   (res_lrc),
    .res_match (res_match)
  );
endmodule

// File: rtl/lrc_gen_chk.sv
module lrc_gen_chk
  import lrc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  in_valid,
  input logic  in_ready,
  input byte_t in_data,
  input logic  in_som,
  input logic  in_eom,
  input logic  res_valid,
  input logic  res_ready,
  input byte_t res_lrc,
  input logic  res_match
);
  // R8: a stalled result holds still
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_lrc) && $stable(res_match)));

  // R8: a stalled result blocks input
  p_stall_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

  // R5: a one-byte message yields a result on the next cycle
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_som && in_eom) |=> res_valid);

  // R5, R7: a result only appears after an accepted end byte or a stall
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready && in_eom) && !(res_valid && !res_ready)) |=> !res_valid);

  // R4: single non-colon byte message negates that byte
  p_negate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_som && in_eom && (in_data != CH_COLON))
      |=> (res_lrc == twos_neg($past(in_data))));
endmodule

bind lrc_gen lrc_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_som    (in_som),
  .in_eom    (in_eom),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_lrc   (res_lrc),
  .res_match (res_match)
);

// File: tb/tb_lrc_gen.sv
`timescale 1ns/1ps
module tb_lrc_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_som = 1'b0;
  logic       in_eom = 1'b0;
  logic [7:0] in_chk = '0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [7:0] res_lrc;
  logic       res_match;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lrc_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_som(in_som), .in_eom(in_eom), .in_chk(in_chk),
    .res_valid(res_valid), .res_ready(res_ready), .res_lrc(res_lrc),
    .res_match(res_match)
  );

  function automatic logic [7:0] ref_lrc(input logic [7:0] s);
    return 8'(9'h0FF - {1'b0, s} + 9'd1);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic put(input logic [7:0] d, input logic s, input logic e,
                     input logic [7:0] c);
    in_valid = 1'b1; in_data = d; in_som = s; in_eom = e; in_chk = c;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_som = 1'b0; in_eom = 1'b0;
  endtask

  task automatic expect_res(input logic [7:0] exp, input logic m, input string req);
    chk(int'(res_valid), 1, {req, " valid"});
    chk(int'(res_lrc), int'(exp), {req, " lrc"});
    chk(int'(res_match), int'(m), {req, " match"});
  endtask

  // colon, body a b, then CR LF
  task automatic framed2(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [7:0] e;
    e = ref_lrc(8'(a + b));
    put(8'h3A, 1'b1, 1'b0, 8'h00);
    put(a, 1'b0, 1'b0, 8'h00);
    put(b, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b0, 8'h00);
    put(8'h0A, 1'b0, 1'b1, e);
    expect_res(e, 1'b1, req);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    logic [7:0] s;
    @(negedge clk);
    chk(int'(res_valid), 0, "R9 reset res_valid");
    chk(int'(in_ready), 1, "R9 reset in_ready");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: stray bytes before any start
    put(8'h41, 1'b0, 1'b1, 8'h00);
    chk(int'(res_valid), 0, "R7 stray eom after reset");
    put(8'h0A, 1'b0, 1'b0, 8'h00);
    put(8'h0A, 1'b0, 1'b1, 8'h00);
    chk(int'(res_valid), 0, "R7 stray LF eom");

    // R1/R4/R6: every single-byte message
    for (int v = 0; v < 256; v++) begin
      e = (v == 8'h3A) ? ref_lrc(8'h00) : ref_lrc(8'(v));
      put(8'(v), 1'b1, 1'b1, (v % 2 == 1) ? e : (e ^ 8'h5A));
      expect_res(e, (v % 2 == 1), "R1 R4 R6 single byte");
      @(negedge clk);
      chk(int'(res_valid), 0, "R5 result drops after take");
    end

    // R3/R4: two-byte bodies, CR LF stripped (R2)
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b++)
        framed2(8'(a), 8'(b), "R2 R3 R4 framed pair");

    // R2: trailers that are not the CR LF pair
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h20, 1'b0, 1'b0, 8'h00);
    put(8'h0A, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h2A), 1'b0, "R2 lone LF summed");
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h20, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h2D), 1'b0, "R2 lone CR summed");
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h0A, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h17), 1'b0, "R2 LF CR summed");
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h0D, 1'b0, 1'b0, 8'h00);
    put(8'h0A, 1'b0, 1'b0, 8'h00); put(8'h0D, 1'b0, 1'b0, 8'h00);
    put(8'h0A, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h17), 1'b0, "R2 inner CR LF summed");

    // R1: non-colon start byte is summed
    put(8'h31, 1'b1, 1'b0, 8'h00); put(8'h32, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b0, 8'h00); put(8'h0A, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h63), 1'b0, "R1 non-colon start");

    // R3: long 0xFF run wraps many times
    s = 8'h00;
    put(8'h3A, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 300; i++) begin
      put(8'hFF, 1'b0, 1'b0, 8'h00);
      s = 8'(s + 8'hFF);
    end
    put(8'h0D, 1'b0, 1'b0, 8'h00); put(8'h0A, 1'b0, 1'b1, 8'h2C);
    expect_res(ref_lrc(s), 1'b1, "R3 wrap");
    chk(int'(ref_lrc(s)), 8'h2C, "R3 wrap arithmetic");

    // R10: restart mid-message
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h55, 1'b0, 1'b0, 8'h00);
    put(8'h66, 1'b0, 1'b0, 8'h00);
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h07, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b0, 8'h00); put(8'h0A, 1'b0, 1'b1, 8'h00);
    expect_res(ref_lrc(8'h07), 1'b0, "R10 restart");

    // R7: stray after a complete message
    put(8'h99, 1'b0, 1'b1, 8'h00);
    chk(int'(res_valid), 0, "R7 stray after message");

    // R8: stalled consumer
    res_ready = 1'b0;
    put(8'h3A, 1'b1, 1'b0, 8'h00); put(8'h10, 1'b0, 1'b0, 8'h00);
    put(8'h0D, 1'b0, 1'b0, 8'h00); put(8'h0A, 1'b0, 1'b1, 8'hF0);
    expect_res(8'hF0, 1'b1, "R8 stalled result");
    repeat (3) @(negedge clk);
    chk(int'(in_ready), 0, "R8 in_ready low");
    expect_res(8'hF0, 1'b1, "R8 result held");
    res_ready = 1'b1;
    @(negedge clk);
    chk(int'(res_valid), 0, "R8 released");
    chk(int'(in_ready), 1, "R8 in_ready back");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule